// File: doc/BRIEF.md
# Dual-Output Programmable Clock Post-Divider

This block divides a fast input clock by a selectable power of two and produces two related outputs. Output A runs at the input rate divided by 2, 4, 8, 16, 32 or 64. Output B runs either at the same rate as A or at half of it. Both outputs have an exact 50% duty cycle. Every output is a registered signal in the input clock domain.

The division setting comes from one of two sources. The first is a set of parallel configuration pins. The second is a single configuration register, which a serial host writes and reads through a simple write/read port. A mode input selects the parallel pins, and when it is set they take priority over the register. A new setting can be applied while the block is running. It takes effect only at a boundary where both outputs finish a full period, so no output phase is ever cut short.

Each output has its own stop input. A stop waits for that output's next falling edge and then holds the output low. A restart always begins with a complete high phase.

Top module: `dual_clk_postdiv`

## Requirements
- R1: The 3-bit ratio code selects the division of output A: 0→2, 1→4, 2→8, 3→16, 4→32, 5→64. Codes 6 and 7 act as 64.
- R2: At every ratio both outputs are high for exactly half of their period and low for the other half.
- R3: When the B-select bit is 0, output B equals output A. When it is 1, output B has twice A's period, and every rising edge of B coincides with a rising edge of A.
- R4: A stop input never shortens a high phase. Once the output is stopped it stays low for as long as stop is held. After release, the output restarts with a full high phase, and the other output keeps running throughout.
- R5: Synchronous active-high reset drives both outputs low, clears the register to 0 (ratio 2, B equal to A), and the outputs then run at ratio 2.
- R6: When pin_mode is 1, the pin fields decide the ratio and the B select, whatever the register holds. When pin_mode is 0, the register decides.
- R7: A write places reg_wr_data (bit 3 = B-select, bits 2:0 = ratio code) in the register, and reg_rd_data shows it from the next cycle on, whatever the pins carry.
- R8: A settings change takes effect only where the B period wraps, so every high or low phase is at least as long as the smaller of the old and new half-periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| pin_mode | input | 1 | 1 selects the parallel pins as the settings source |
| pin_ratio | input | 3 | Ratio code from the pins |
| pin_b_half | input | 1 | B-select from the pins (1 = half of A) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 4 | Write value: {B-select, ratio code} |
| reg_rd_data | output | 4 | Current register contents |
| stop_a | input | 1 | Stop request for output A |
| stop_b | input | 1 | Stop request for output B |
| out_a | output | 1 | Divided output A |
| out_b | output | 1 | Divided output B |

## Verification
A register write shows on reg_rd_data one cycle after the strobe. A new setting reaches the outputs at the next B-period wrap plus one output register, which is at most 129 cycles. The bench therefore waits 300 cycles after any settings change before it measures phase lengths. Stop and restart are judged by the lengths of complete high and low runs sampled on the falling clock edge, so the bench never depends on the exact cycle in which a request arrives. Every phase length is counted from an observed output edge, not from the stimulus time.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int CODE_W = 3;
  typedef struct packed {
    logic              b_half;
    logic [CODE_W-1:0] code;
  } div_cfg_t;
  localparam int CFG_W = CODE_W + 1;
  localparam div_cfg_t CFG_DEFAULT = '{b_half: 1'b0, code: '0};
endpackage

// File: rtl/dcd_cfg_src.sv
module dcd_cfg_src
  import dcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pin_mode,
  input  div_cfg_t pin_cfg,
  input  logic     wr_en,
  input  div_cfg_t wr_cfg,
  output div_cfg_t rd_cfg,
  output div_cfg_t sel_cfg
);
  div_cfg_t reg_q;

  always_ff @(posedge clk) begin
    if (rst)        reg_q <= CFG_DEFAULT;
    else if (wr_en) reg_q <= wr_cfg;
  end

  assign rd_cfg  = reg_q;
  assign sel_cfg = pin_mode ? pin_cfg : reg_q;

  assert_reg_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (reg_q == $past(wr_cfg)));
endmodule

// File: rtl/dcd_phase_gen.sv
module dcd_phase_gen
  import dcd_pkg::*;
#(
  parameter int MAX_LOG = 6
) (
  input  logic     clk,
  input  logic     rst,
  input  div_cfg_t sel_cfg,
  output logic     raw_a,
  output logic     raw_b
);
  localparam int PH_W  = MAX_LOG + 1;
  localparam int LOG_W = $clog2(PH_W + 1);

  logic [PH_W-1:0]  ph;
  logic [LOG_W-1:0] act_k;
  logic             act_half;
  logic [LOG_W-1:0] new_k;
  logic [LOG_W-1:0] b_k;
  logic [PH_W:0]    span;
  logic [PH_W-1:0]  last_ph;

  always_comb begin
    if (int'(sel_cfg.code) >= MAX_LOG) new_k = LOG_W'(MAX_LOG - 1);
    else                               new_k = LOG_W'(sel_cfg.code);
  end

  assign b_k     = act_half ? act_k + LOG_W'(1) : act_k;
  assign span    = (PH_W+1)'(1) << (b_k + LOG_W'(1));
  assign last_ph = PH_W'(span - (PH_W+1)'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= '0;
      act_k    <= '0;
      act_half <= 1'b0;
    end else if (ph == last_ph) begin
      ph       <= '0;
      act_k    <= new_k;
      act_half <= sel_cfg.b_half;
    end else begin
      ph <= ph + PH_W'(1);
    end
  end

  assign raw_a = ~ph[act_k];
  assign raw_b = ~ph[b_k];

  assert_cfg_at_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    ((act_k != $past(act_k)) || (act_half != $past(act_half))) |-> (ph == '0));
endmodule

// File: rtl/dcd_out_gate.sv
module dcd_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic stop,
  output logic out,
  output logic raw_q
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b1;
      out   <= 1'b0;
      raw_q <= 1'b0;
    end else begin
      raw_q <= raw;
      out   <= raw & en_q;
      if (!raw) en_q <= ~stop;
    end
  end

  assert_no_runt_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(out) |-> $fell(raw_q));
  assert_no_runt_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out) |-> $rose(raw_q));
endmodule

// File: rtl/dual_clk_postdiv.sv
module dual_clk_postdiv
  import dcd_pkg::*;
#(
  parameter int MAX_LOG = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_mode,
  input  logic [CODE_W-1:0] pin_ratio,
  input  logic             pin_b_half,
  input  logic             reg_wr_en,
  input  logic [CFG_W-1:0] reg_wr_data,
  output logic [CFG_W-1:0] reg_rd_data,
  input  logic             stop_a,
  input  logic             stop_b,
  output logic             out_a,
  output logic             out_b
);
  localparam int N_OUT = 2;

  div_cfg_t pin_cfg, wr_cfg, rd_cfg, sel_cfg;
  logic [N_OUT-1:0] raw, stop, outs, raw_q;

  assign pin_cfg     = '{b_half: pin_b_half, code: pin_ratio};
  assign wr_cfg      = div_cfg_t'(reg_wr_data);
  assign reg_rd_data = CFG_W'(rd_cfg);

  dcd_cfg_src u_cfg (
    .clk(clk), .rst(rst), .pin_mode(pin_mode), .pin_cfg(pin_cfg),
    .wr_en(reg_wr_en), .wr_cfg(wr_cfg), .rd_cfg(rd_cfg), .sel_cfg(sel_cfg)
  );

  dcd_phase_gen #(.MAX_LOG(MAX_LOG)) u_phase (
    .clk(clk), .rst(rst), .sel_cfg(sel_cfg), .raw_a(raw[0]), .raw_b(raw[1])
  );

  assign stop = {stop_b, stop_a};

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    dcd_out_gate u_gate (
      .clk(clk), .rst(rst), .raw(raw[i]), .stop(stop[i]),
      .out(outs[i]), .raw_q(raw_q[i])
    );
  end

  assign out_a = outs[0];
  assign out_b = outs[1];

  assert_b_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_q[1]) |-> $rose(raw_q[0]));
  assert_reset_low_R5: assert property (@(posedge clk)
    rst |=> (!out_a && !out_b));
endmodule

// File: tb/dual_clk_postdiv_tb.sv
module dual_clk_postdiv_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic pin_mode = 0, pin_b_half = 0, reg_wr_en = 0, stop_a = 0, stop_b = 0;
  logic [2:0] pin_ratio = 0;
  logic [3:0] reg_wr_data = 0;
  logic [3:0] reg_rd_data;
  logic out_a, out_b;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_clk_postdiv u_dut (
    .clk(clk), .rst(rst), .pin_mode(pin_mode), .pin_ratio(pin_ratio),
    .pin_b_half(pin_b_half), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .stop_a(stop_a), .stop_b(stop_b),
    .out_a(out_a), .out_b(out_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic get_out(input int sel);
    return sel == 1 ? out_b : out_a;
  endfunction

  task automatic measure(input int sel, output int hi, output int lo);
    int t = 0;
    do begin @(negedge clk); t++; end while (get_out(sel) !== 1'b0 && t < 1000);
    do begin @(negedge clk); t++; end while (get_out(sel) !== 1'b1 && t < 1000);
    hi = 0;
    while (get_out(sel) === 1'b1 && t < 1000) begin hi++; @(negedge clk); t++; end
    lo = 0;
    while (get_out(sel) === 1'b0 && t < 1000) begin lo++; @(negedge clk); t++; end
  endtask

  task automatic shortest_run(input int sel, input int ncyc, output int minrun);
    logic prev;
    int run = 0;
    bit first = 1;
    minrun = 1000;
    @(negedge clk);
    prev = get_out(sel);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      run++;
      if (get_out(sel) !== prev) begin
        if (!first && run < minrun) minrun = run;
        first = 0;
        run = 0;
        prev = get_out(sel);
      end
    end
  endtask

  task automatic write_reg(input logic [3:0] v);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  task automatic t_reset();
    int hi, lo;
    repeat (3) @(negedge clk);
    check(out_a === 0 && out_b === 0, "R5 outputs low in reset", int'(out_a), 0);
    check(reg_rd_data === 4'h0, "R5 register default", int'(reg_rd_data), 0);
    rst = 0;
    measure(0, hi, lo);
    check(hi == 1 && lo == 1, "R5 default ratio 2 high", hi, 1);
    measure(1, hi, lo);
    check(hi == 1 && lo == 1, "R5 default B equals A", hi, 1);
  endtask

  task automatic t_ratios();
    int hi, lo, h;
    for (int c = 0; c < 8; c++) begin
      write_reg(4'(c));
      settle();
      h = (c > 5) ? 32 : (1 << c);
      measure(0, hi, lo);
      check(hi == h, $sformatf("R1 A high code %0d", c), hi, h);
      check(lo == h, $sformatf("R2 A low code %0d", c), lo, h);
      measure(1, hi, lo);
      check(hi == h && lo == h, $sformatf("R3 B 1x code %0d", c), hi, h);
    end
  endtask

  task automatic t_bhalf();
    int hi, lo, bad = 0;
    logic pa, pb;
    write_reg(4'b1010);
    settle();
    measure(1, hi, lo);
    check(hi == 8 && lo == 8, "R3 B half high/low", hi, 8);
    measure(0, hi, lo);
    check(hi == 4 && lo == 4, "R2 A under B half", hi, 4);
    @(negedge clk); pa = out_a; pb = out_b;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (out_b && !pb && !(out_a && !pa)) bad++;
      pa = out_a; pb = out_b;
    end
    check(bad == 0, "R3 B rises align with A rises", bad, 0);
  endtask

  task automatic t_readback();
    write_reg(4'b1011);
    pin_ratio = 3'd5; pin_b_half = 0;
    @(negedge clk);
    check(reg_rd_data === 4'b1011, "R7 register read back", int'(reg_rd_data), 11);
  endtask

  task automatic t_pins();
    int hi, lo;
    write_reg(4'b0001);
    pin_ratio = 3'd3; pin_b_half = 1; pin_mode = 1;
    settle();
    measure(0, hi, lo);
    check(hi == 8 && lo == 8, "R6 pins set A ratio", hi, 8);
    measure(1, hi, lo);
    check(hi == 16, "R6 pins set B half", hi, 16);
    check(reg_rd_data === 4'b0001, "R7 register unaffected by pins", int'(reg_rd_data), 1);
    pin_mode = 0;
    settle();
    measure(0, hi, lo);
    check(hi == 2 && lo == 2, "R6 register back in control", hi, 2);
  endtask

  task automatic t_change();
    int m;
    write_reg(4'b0011);
    settle();
    fork
      shortest_run(0, 400, m);
      begin repeat (37) @(negedge clk); write_reg(4'b0001); end
    join
    check(m >= 2, "R8 no short phase 16->4", m, 2);
    fork
      shortest_run(0, 400, m);
      begin repeat (13) @(negedge clk); write_reg(4'b0100); end
    join
    check(m >= 2, "R8 no short phase 4->32", m, 2);
  endtask

  task automatic t_stop();
    int m, hi, lo, nz = 0;
    write_reg(4'b0010);
    settle();
    fork
      shortest_run(0, 100, m);
      begin repeat (6) @(negedge clk); stop_a = 1; end
    join
    check(m >= 4, "R4 stop keeps full phases", m, 4);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_a !== 1'b0) nz++;
    end
    check(nz == 0, "R4 A held low while stopped", nz, 0);
    measure(1, hi, lo);
    check(hi == 4 && lo == 4, "R4 B runs while A stopped", hi, 4);
    fork
      shortest_run(0, 100, m);
      begin repeat (3) @(negedge clk); stop_a = 0; end
    join
    check(m >= 4, "R4 restart with full high phase", m, 4);
    stop_b = 1;
    repeat (30) @(negedge clk);
    nz = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_b !== 1'b0) nz++;
    end
    check(nz == 0, "R4 B held low while stopped", nz, 0);
    measure(0, hi, lo);
    check(hi == 4 && lo == 4, "R4 A runs while B stopped", hi, 4);
    stop_b = 0;
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_bhalf();
    t_readback();
    t_pins();
    t_change();
    t_stop();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule